// File: doc/BRIEF.md
# Gain-Change Indicator Steering Logic

This block turns a gain-detect event from the receive datapath into level indicators that drive an external attenuator or gain stage ahead of an ADC. Each detect sample passes through a short programmable delay line. The delay lets the indicator line up with the ADC pipeline latency and with the time the analog gain change needs to settle. The delayed detect is then steered onto two indicator outputs, A and B.

Single-input mode and dual-input mode steer the detect differently. In single-input mode, output A carries the indication and output B is always its complement. In dual-input (time-multiplexed) mode, an external select pin picks the output for each sample, and the other output rests at its inactive level. A polarity bit sets the active level of both outputs.

The block holds `NCH` independent channels. Each channel has its own detect input, select pin and control set, and serves one ADC input port.

Top module: `gain_ind_steer`

## Requirements
- R1: When a channel's `dual_mode_i` bit is 0, `ind_a_o` is at the active level when the delayed detect is 1 and at the inactive level otherwise, and `ind_b_o` is always the logical complement of `ind_a_o`.
- R2: When `dual_mode_i` is 1 and `tdm_sel_i` is 0, `ind_a_o` carries the delayed detect and `ind_b_o` holds its inactive level. When `tdm_sel_i` is 1, `ind_b_o` carries it and `ind_a_o` holds its inactive level.
- R3: `act_high_i` = 1 makes the active level 1 and the inactive level 0. `act_high_i` = 0 makes the active level 0 and the inactive level 1. This applies to both outputs in both modes.
- R4: With latency L (0 to 7) in a channel's 3-bit latency field, the outputs between rising edge k+L and rising edge k+L+1 reflect the detect value sampled at rising edge k.
- R5: Channels are independent. Channel c uses bit c of each 1-bit control bus, and bits [3c+2:3c] of `lat_i`, as its latency field.
- R6: A rising edge with `rst` high clears every delay stage. Afterwards the delayed detect reads 0 until new detect samples reach the selected tap, so `ind_a_o` is inactive in both modes.
- R7: A change of the latency field takes effect in the same cycle. It selects a different stage of the existing history, and no stored sample is dropped or flushed.
- R8: `tdm_sel_i`, `dual_mode_i` and `act_high_i` act on the outputs within the same cycle, with no register between them and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| det_i | input | NCH | Gain-detect event per channel |
| tdm_sel_i | input | NCH | Channel-select pin per channel (dual mode only) |
| dual_mode_i | input | NCH | 0 = single input, 1 = time-multiplexed dual input |
| act_high_i | input | NCH | 1 = indicators active high, 0 = active low |
| lat_i | input | NCH*3 | Per-channel detect latency, 0 to 7 sample clocks |
| ind_a_o | output | NCH | Indicator A per channel |
| ind_b_o | output | NCH | Indicator B per channel |

## Verification
A detect sample taken at a rising edge must appear on the outputs L edges later. It must stay there until the next edge. Mode, polarity and select changes must show up in the same cycle.

The bench keeps a per-channel history of sampled detect values in its own array. It indexes that history with the current latency and compares both outputs on every falling edge. Inputs are driven just after each rising edge. Latency sweeps, isolated pulses at the extreme latencies, mid-stream latency changes and resets with pulses still in flight each have their own phase.

// File: rtl/gis_pkg.sv
package gis_pkg;

    // Width of the per-channel latency field; the deepest tap follows from it.
    localparam int LAT_W   = 3;
    localparam int MAX_LAT = (1 << LAT_W) - 1;

    typedef logic [LAT_W-1:0] lat_t;

    typedef struct packed {
        logic dual;     // 1: time-multiplexed dual input
        logic act_hi;   // 1: indicators active high
        lat_t lat;      // detect delay in sample clocks
    } gis_cfg_t;

    typedef struct packed {
        logic a;
        logic b;
    } ind_pair_t;

    // Drive level for an indicator given whether it is asserted.
    function automatic logic drive_level(logic asserted, logic act_hi);
        return asserted ? act_hi : ~act_hi;
    endfunction

    // Route a delayed detect onto the two indicators.
    function automatic ind_pair_t route(logic hit, logic sel, gis_cfg_t cfg);
        ind_pair_t r;
        if (!cfg.dual) begin
            r.a = drive_level(hit, cfg.act_hi);
            r.b = ~r.a;
        end else begin
            r.a = drive_level(hit & ~sel, cfg.act_hi);
            r.b = drive_level(hit &  sel, cfg.act_hi);
        end
        return r;
    endfunction

endpackage

// File: rtl/gis_delay_line.sv
module gis_delay_line
    import gis_pkg::*;
#(
    parameter int DEPTH = MAX_LAT
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  lat_t lat,
    output logic dout
);
    localparam int NSTG = DEPTH + 1;

    logic [NSTG-1:0] stg;

    // Stage 0 is the input register; later stages each add one clock.
    always_ff @(posedge clk) begin
        if (rst) stg[0] <= 1'b0;
        else     stg[0] <= din;
    end

    for (genvar i = 1; i < NSTG; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= 1'b0;
            else     stg[i] <= stg[i-1];
        end
    end

    // The tap select is combinational, so a new latency reuses the stored history.
    always_comb begin
        dout = 1'b0;
        for (int k = 0; k < NSTG; k++) begin
            if (int'(lat) == k) dout = stg[k];
        end
    end

endmodule

// File: rtl/gis_steer.sv
module gis_steer
    import gis_pkg::*;
(
    input  logic     hit,
    input  logic     sel,
    input  gis_cfg_t cfg,
    output logic     ind_a,
    output logic     ind_b
);
    ind_pair_t pair;

    always_comb begin
        pair  = route(hit, sel, cfg);
        ind_a = pair.a;
        ind_b = pair.b;
    end

endmodule

// File: rtl/gis_channel.sv
module gis_channel
    import gis_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     det,
    input  logic     sel,
    input  gis_cfg_t cfg,
    output logic     ind_a,
    output logic     ind_b
);
    logic hit;

    gis_delay_line #(.DEPTH(MAX_LAT)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (det),
        .lat  (cfg.lat),
        .dout (hit)
    );

    gis_steer u_steer (
        .hit   (hit),
        .sel   (sel),
        .cfg   (cfg),
        .ind_a (ind_a),
        .ind_b (ind_b)
    );

endmodule

// File: rtl/gain_ind_steer.sv
module gain_ind_steer
    import gis_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCH-1:0]     det_i,
    input  logic [NCH-1:0]     tdm_sel_i,
    input  logic [NCH-1:0]     dual_mode_i,
    input  logic [NCH-1:0]     act_high_i,
    input  logic [NCH*LAT_W-1:0] lat_i,
    output logic [NCH-1:0]     ind_a_o,
    output logic [NCH-1:0]     ind_b_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gis_cfg_t cfg;

        always_comb begin
            cfg.dual   = dual_mode_i[c];
            cfg.act_hi = act_high_i[c];
            cfg.lat    = lat_i[c*LAT_W +: LAT_W];
        end

        gis_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .det   (det_i[c]),
            .sel   (tdm_sel_i[c]),
            .cfg   (cfg),
            .ind_a (ind_a_o[c]),
            .ind_b (ind_b_o[c])
        );
    end

endmodule

// File: rtl/gain_ind_steer_chk.sv
module gain_ind_steer_chk
    import gis_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCH-1:0]         det_i,
    input logic [NCH-1:0]         tdm_sel_i,
    input logic [NCH-1:0]         dual_mode_i,
    input logic [NCH-1:0]         act_high_i,
    input logic [NCH*LAT_W-1:0]   lat_i,
    input logic [NCH-1:0]         ind_a_o,
    input logic [NCH-1:0]         ind_b_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        lat_t lat_c;
        assign lat_c = lat_i[c*LAT_W +: LAT_W];

        // R1
        single_complement_chk: assert property (@(posedge clk) disable iff (rst)
            !dual_mode_i[c] |-> (ind_b_o[c] == ~ind_a_o[c]));

        // R2
        dual_b_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (dual_mode_i[c] && !tdm_sel_i[c]) |-> (ind_b_o[c] == ~act_high_i[c]));

        // R2
        dual_a_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (dual_mode_i[c] && tdm_sel_i[c]) |-> (ind_a_o[c] == ~act_high_i[c]));

        // R4
        zero_latency_chk: assert property (@(posedge clk) disable iff (rst)
            det_i[c] |=> (lat_c != '0 || dual_mode_i[c] || ind_a_o[c] == act_high_i[c]));

        // R4
        one_latency_chk: assert property (@(posedge clk) disable iff (rst)
            (lat_c == LAT_W'(1) && !dual_mode_i[c] && $past(det_i[c], 2)
             && !$past(rst) && !$past(rst, 2)) |-> (ind_a_o[c] == act_high_i[c]));

        // R6
        reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (ind_a_o[c] == ~act_high_i[c]));
    end

endmodule

bind gain_ind_steer gain_ind_steer_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .det_i       (det_i),
    .tdm_sel_i   (tdm_sel_i),
    .dual_mode_i (dual_mode_i),
    .act_high_i  (act_high_i),
    .lat_i       (lat_i),
    .ind_a_o     (ind_a_o),
    .ind_b_o     (ind_b_o)
);

// File: tb/gain_ind_steer_bench.sv
module gain_ind_steer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int LW = 3;
    localparam int WATCHDOG = 50000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    det_i = '0;
    logic [NCH-1:0]    tdm_sel_i = '0;
    logic [NCH-1:0]    dual_mode_i = '0;
    logic [NCH-1:0]    act_high_i = '1;
    logic [NCH*LW-1:0] lat_i = '0;
    logic [NCH-1:0]    ind_a_o;
    logic [NCH-1:0]    ind_b_o;

    gain_ind_steer #(.NCH(NCH)) u_gain_ind_steer (
        .clk         (clk),
        .rst         (rst),
        .det_i       (det_i),
        .tdm_sel_i   (tdm_sel_i),
        .dual_mode_i (dual_mode_i),
        .act_high_i  (act_high_i),
        .lat_i       (lat_i),
        .ind_a_o     (ind_a_o),
        .ind_b_o     (ind_b_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    bit    started  = 0;
    string cur_tag  = "R6";
    int    hist [NCH][$];   // newest sample at index 0

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Reference history of sampled detect values
    always @(posedge clk) begin
        started <= 1'b1;
        cycles  <= cycles + 1;
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                hist[c].delete();
                for (int k = 0; k < 8; k++) hist[c].push_back(0);
            end else begin
                hist[c].push_front(int'(det_i[c]));
                void'(hist[c].pop_back());
            end
        end
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (started) begin
            for (int c = 0; c < NCH; c++) begin
                int  l;
                bit  hit, pol, ea, eb;
                l   = int'(lat_i[c*LW +: LW]);
                hit = (hist[c][l] != 0);
                pol = act_high_i[c];
                if (!dual_mode_i[c]) begin
                    ea = hit ? pol : !pol;
                    eb = !ea;
                end else begin
                    ea = (hit && !tdm_sel_i[c]) ? pol : !pol;
                    eb = (hit &&  tdm_sel_i[c]) ? pol : !pol;
                end
                n_checks++;
                if (ind_a_o[c] !== ea || ind_b_o[c] !== eb) begin
                    n_fails++;
                    $display("FAIL %s ch%0d: actual a=%b b=%b expected a=%b b=%b",
                             cur_tag, c, ind_a_o[c], ind_b_o[c], ea, eb);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(int c, bit dual, bit pol, int lat);
        dual_mode_i[c] = dual;
        act_high_i[c]  = pol;
        lat_i[c*LW +: LW] = LW'(lat);
    endtask

    // density: 0 = random detect, 1 = sparse single pulses
    task automatic run(int n, int density, bit rand_sel, bit rand_lat);
        for (int i = 0; i < n; i++) begin
            for (int c = 0; c < NCH; c++) begin
                if (density == 0) det_i[c] = 1'($urandom);
                else              det_i[c] = (($urandom % 12) == 0);
                if (rand_sel) tdm_sel_i[c] = 1'($urandom);
                if (rand_lat) lat_i[c*LW +: LW] = LW'($urandom);
            end
            step();
        end
    endtask

    initial begin
        // R6: reset state and behaviour right after release
        cur_tag = "R6";
        set_cfg(0, 0, 1, 3);
        set_cfg(1, 1, 0, 5);
        repeat (3) step();
        rst = 1'b0;
        run(20, 0, 1, 0);

        // R1: single mode across every latency
        cur_tag = "R1";
        for (int l = 0; l < 8; l++) begin
            set_cfg(0, 0, 1, l);
            set_cfg(1, 0, 1, 7 - l);
            run(30, 0, 1, 0);
        end

        // R3: active-low polarity in both modes
        cur_tag = "R3";
        set_cfg(0, 0, 0, 2);
        set_cfg(1, 1, 0, 4);
        run(80, 0, 1, 0);

        // R2: dual mode with the select pin varying
        cur_tag = "R2";
        for (int l = 0; l < 8; l += 3) begin
            set_cfg(0, 1, 1, l);
            set_cfg(1, 1, 0, l);
            run(60, 0, 1, 0);
        end

        // R4: isolated pulses at the extreme latencies
        cur_tag = "R4";
        foreach (lat_i[b]) lat_i[b] = 1'b0;
        set_cfg(0, 0, 1, 7);
        set_cfg(1, 0, 0, 0);
        run(150, 1, 0, 0);
        set_cfg(0, 1, 1, 0);
        set_cfg(1, 1, 1, 7);
        run(150, 1, 1, 0);

        // R5: channels with different modes and latencies at once
        cur_tag = "R5";
        for (int i = 0; i < 10; i++) begin
            set_cfg(0, 1'($urandom), 1'($urandom), int'($urandom % 8));
            set_cfg(1, 1'($urandom), 1'($urandom), int'($urandom % 8));
            run(25, 0, 1, 0);
        end

        // R7: latency rewritten every cycle
        cur_tag = "R7";
        set_cfg(0, 0, 1, 0);
        set_cfg(1, 1, 1, 0);
        run(200, 0, 1, 1);

        // R8: select, mode and polarity changing within live traffic
        cur_tag = "R8";
        for (int i = 0; i < 150; i++) begin
            for (int c = 0; c < NCH; c++) begin
                dual_mode_i[c] = 1'($urandom);
                act_high_i[c]  = 1'($urandom);
                tdm_sel_i[c]   = ~tdm_sel_i[c];
                det_i[c]       = 1'($urandom);
            end
            step();
        end

        // R6: reset with pulses still in the delay line
        cur_tag = "R6";
        set_cfg(0, 0, 1, 7);
        set_cfg(1, 1, 1, 6);
        det_i = '1;
        repeat (6) step();
        rst = 1'b1;
        det_i = '1;
        repeat (2) step();
        rst = 1'b0;
        det_i = '0;
        run(10, 1, 1, 0);

        step();
        finish_run();
    end

endmodule